// File: doc/BRIEF.md
# CRC-Protected Fixed-Frame Link Transmitter

This block turns a stream of 32-bit object words into a continuous run of fixed-length link frames, one frame per bunch-crossing tick. The word clock runs seven times faster than the crossing tick, so one link word leaves on every clock and frames follow each other without gaps. A frame has seven words. Six of them are payload and the seventh is a trailer. Payload slots that receive no valid object word are sent as zeros. The first word of every frame carries a comma character in its low byte, and a control flag marks that byte for the serializer.

The trailer holds the bunch-crossing number, an error flag and a 9-bit CRC. The CRC covers all seven words, including the comma byte and the trailer itself, with the trailer's CRC field taken as zero during the calculation. The final CRC is therefore only known once the trailer has been formed. For this reason the transmit stream passes through a delay line one frame deep, and the CRC is written into the trailer while the trailer moves along that line. A sync pulse from the upstream merging stage aligns frame starts to crossings. When no sync pulse arrives, the block keeps producing frames on its own, with empty payload and a correct CRC, so the receiver never loses framing.

Top module: `lnk_frame_tx`

## Requirements
- R1: While `rst_n` is low, `tx_data` and `tx_ctrl` are all zeros. They also stay all zeros for the first 7 clocks after reset is released. The first internal frame starts at the first clock after release.
- R2: A clock in which `bx_sync` is high forms word position 0 of a new frame. Positions then advance by one per clock from 0 to 6 and wrap back to 0. A sync pulse at any position restarts at 0, which drops the unfinished frame together with its trailer.
- R3: At positions 1 to 5, the word is `obj_data` when `obj_valid` is high and zero otherwise. At position 0 the same rule sets bits [31:8].
- R4: At position 0, bits [7:0] are the comma code 0xBC and `tx_ctrl` is 2'b01. For every other word `tx_ctrl` is 2'b00.
- R5: The trailer (position 6) is laid out as follows. Bits [8:0] hold the CRC. Bits [12:9] hold `bx_num` as sampled at position 0 of the same frame. Bit 13 holds `bx_err` as sampled at position 0. Bits [31:14] are zero. The object inputs have no effect on the trailer.
- R6: The CRC uses the polynomial x^9+x^6+x^5+x^4+x^3+1 and starts from all ones at position 0. It takes in each of the seven 32-bit data words most significant bit first, with trailer bits [8:0] taken as zero.
- R7: With `bx_sync` held low, frames repeat every 7 clocks indefinitely. When no object is valid, each of these frames has zero payload, a comma, and a CRC computed by R6.
- R8: The word formed at a given clock appears on `tx_data`/`tx_ctrl` exactly 7 clocks later. One word is output per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_data | input | 32 | Object word from the merging stage |
| obj_valid | input | 1 | `obj_data` holds a real object this clock |
| bx_sync | input | 1 | Marks the first word of a crossing's group |
| bx_num | input | 4 | Bunch-crossing number, sampled at frame start |
| bx_err | input | 1 | Upstream error indication, sampled at frame start |
| tx_data | output | 32 | Link data word |
| tx_ctrl | output | 2 | Per-byte control flags for the two low bytes (bit 0 marks the comma byte) |

## Verification
The bench builds the block with its default 7-word frame, 32-bit words and 9-bit CRC. The frame is short enough that a few thousand clocks pass through several hundred complete frames. Over that span the bench sees aligned sync pulses, missing sync pulses and sync pulses that cut a frame short at every position. It also covers random bunch-crossing numbers and error flags, and random gaps in the object stream. Each of these is compared word for word against a frame model, with the CRC recomputed in the bench, 7 clocks after the word was formed.

// File: rtl/lnk_frame_pkg.sv
package lnk_frame_pkg;

  localparam int DW = 32;   // link data width
  localparam int CW = 9;    // CRC width
  localparam int BW = 4;    // bunch-crossing number width
  localparam int KW = 2;    // control flags per word

  localparam int BCN_LSB = CW;        // trailer field positions
  localparam int ERR_BIT = CW + BW;
  localparam int TRL_USED = ERR_BIT + 1;

  localparam logic [7:0]    COMMA_K  = 8'hBC;
  localparam logic [CW-1:0] CRC_POLY = 9'h079;
  localparam logic [CW-1:0] CRC_SEED = 9'h1FF;

  typedef struct packed {
    logic [KW-1:0] k;
    logic [DW-1:0] d;
  } lnk_word_t;

  // One word through the CRC, most significant bit first.
  function automatic logic [CW-1:0] crc_absorb(input logic [CW-1:0] c,
                                               input logic [DW-1:0] d);
    logic [CW-1:0] r;
    logic          fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[CW-1] ^ d[i];
      r  = {r[CW-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/lnk_frame_pos.sv
module lnk_frame_pos #(
  parameter int FRAME_WORDS = 7,
  parameter int PW          = $clog2(FRAME_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [PW-1:0] pos_o
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_WORDS - 1);

  logic [PW-1:0] nxt_q, nxt_d, cur;

  always_comb begin
    cur   = sync_i ? '0 : nxt_q;
    nxt_d = (cur == LAST) ? '0 : cur + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nxt_q <= '0;
    else        nxt_q <= nxt_d;
  end

  assign pos_o = cur;

endmodule

// File: rtl/lnk_frame_asm.sv
module lnk_frame_asm
  import lnk_frame_pkg::*;
#(
  parameter int FRAME_WORDS = 7,
  parameter int PW          = $clog2(FRAME_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pos_i,
  input  logic [DW-1:0] obj_data,
  input  logic          obj_valid,
  input  logic [BW-1:0] bx_num,
  input  logic          bx_err,
  output lnk_word_t     word_o,
  output logic          first_o,
  output logic          last_o
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_WORDS - 1);

  logic          first, last;
  logic [BW-1:0] bcn_q, bcn_d;
  logic          err_q, err_d;
  lnk_word_t     w;

  always_comb begin
    first = (pos_i == '0);
    last  = (pos_i == LAST);
    bcn_d = first ? bx_num : bcn_q;
    err_d = first ? bx_err : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcn_q <= '0;
      err_q <= 1'b0;
    end else begin
      bcn_q <= bcn_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    w = '0;
    if (last) begin
      w.d[BCN_LSB +: BW] = bcn_q;
      w.d[ERR_BIT]       = err_q;
    end else begin
      if (obj_valid) w.d = obj_data;
      if (first) begin
        w.d[7:0] = COMMA_K;
        w.k      = KW'(1);
      end
    end
  end

  assign word_o  = w;
  assign first_o = first;
  assign last_o  = last;

endmodule

// File: rtl/lnk_crc_acc.sv
module lnk_crc_acc
  import lnk_frame_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);

  logic [CW-1:0] crc_q, crc_d;

  always_comb crc_d = crc_absorb(first_i ? CRC_SEED : crc_q, data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/lnk_out_delay.sv
module lnk_out_delay
  import lnk_frame_pkg::*;
#(
  parameter int DEPTH = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lnk_word_t     word_i,
  input  logic          last_i,
  input  logic [CW-1:0] crc_i,
  output lnk_word_t     word_o
);

  lnk_word_t stg_q [DEPTH];
  lnk_word_t patched;
  logic      tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q[0] <= '0;
      tag_q    <= 1'b0;
    end else begin
      stg_q[0] <= word_i;
      tag_q    <= last_i;
    end
  end

  // The CRC register finished the trailer on the same edge that loaded stage 0.
  always_comb begin
    patched = stg_q[0];
    if (tag_q) patched.d[CW-1:0] = crc_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else if (i == 1) stg_q[i] <= patched;
      else             stg_q[i] <= stg_q[i-1];
    end
  end

  assign word_o = stg_q[DEPTH-1];

endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx
  import lnk_frame_pkg::*;
#(
  parameter int FRAME_WORDS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   obj_data,
  input  logic          obj_valid,
  input  logic          bx_sync,
  input  logic [3:0]    bx_num,
  input  logic          bx_err,
  output logic [31:0]   tx_data,
  output logic [1:0]    tx_ctrl
);

  localparam int PW = $clog2(FRAME_WORDS);

  logic [PW-1:0] pos_w;
  lnk_word_t     asm_w, out_w;
  logic          first_w, last_w;
  logic [CW-1:0] crc_w;

  lnk_frame_pos #(.FRAME_WORDS(FRAME_WORDS), .PW(PW)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (bx_sync),
    .pos_o  (pos_w)
  );

  lnk_frame_asm #(.FRAME_WORDS(FRAME_WORDS), .PW(PW)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_i     (pos_w),
    .obj_data  (obj_data),
    .obj_valid (obj_valid),
    .bx_num    (bx_num),
    .bx_err    (bx_err),
    .word_o    (asm_w),
    .first_o   (first_w),
    .last_o    (last_w)
  );

  lnk_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_i (first_w),
    .data_i  (asm_w.d),
    .crc_o   (crc_w)
  );

  lnk_out_delay #(.DEPTH(FRAME_WORDS)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_i (asm_w),
    .last_i (last_w),
    .crc_i  (crc_w),
    .word_o (out_w)
  );

  assign tx_data = out_w.d;
  assign tx_ctrl = out_w.k;

endmodule

// File: rtl/lnk_frame_tx_chk.sv
module lnk_frame_tx_chk
  import lnk_frame_pkg::*;
#(
  parameter int FRAME_WORDS = 7
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bx_sync,
  input logic                             obj_valid,
  input logic [$clog2(FRAME_WORDS)-1:0]   pos,
  input lnk_word_t                        asm_w,
  input logic [DW-1:0]                    tx_data,
  input logic [KW-1:0]                    tx_ctrl
);

  localparam int PW = $clog2(FRAME_WORDS);
  localparam logic [PW-1:0] LAST = PW'(FRAME_WORDS - 1);

  logic [PW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (tx_ctrl[0]) begin
      cnt_q  <= PW'(1);
      seen_q <= 1'b1;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
    end
  end

  p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bx_sync |=> (pos == PW'(1) || bx_sync));

  p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |=> (pos == '0));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!obj_valid && pos != '0 && pos != LAST) |-> (asm_w.d == '0));

  p_comma_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctrl[0] |-> (tx_data[7:0] == COMMA_K));

  p_trailer_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cnt_q == LAST && !tx_ctrl[0]) |->
      (tx_data[DW-1:TRL_USED] == '0 && tx_ctrl == '0));

endmodule

bind lnk_frame_tx lnk_frame_tx_chk #(.FRAME_WORDS(FRAME_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bx_sync   (bx_sync),
  .obj_valid (obj_valid),
  .pos       (pos_w),
  .asm_w     (asm_w),
  .tx_data   (tx_data),
  .tx_ctrl   (tx_ctrl)
);

// File: tb/lnk_frame_tx_tb.sv
module lnk_frame_tx_tb;

  localparam int FW = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] obj_data;
  logic        obj_valid;
  logic        bx_sync;
  logic [3:0]  bx_num;
  logic        bx_err;
  logic [31:0] tx_data;
  logic [1:0]  tx_ctrl;

  always #4 clk = ~clk;

  lnk_frame_tx #(.FRAME_WORDS(FW)) u_dut (
    .clk (clk), .rst_n (rst_n), .obj_data (obj_data), .obj_valid (obj_valid),
    .bx_sync (bx_sync), .bx_num (bx_num), .bx_err (bx_err),
    .tx_data (tx_data), .tx_ctrl (tx_ctrl)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic [33:0] exp_w [8];
  string       exp_t [8];
  int          k;
  int          mnext;
  logic [8:0]  mcrc;
  logic [3:0]  mbcn;
  logic        merr;
  string       ph;

  // Reference CRC of R6: x^9+x^6+x^5+x^4+x^3+1, MSB first.
  function automatic logic [8:0] ref_crc(input logic [8:0] c, input logic [31:0] d);
    logic [8:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[8] ^ d[i]) r = {r[7:0], 1'b0} ^ 9'b0_0111_1001;
      else             r = {r[7:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge: compare the output, then drive one clock.
  task automatic step(input bit s, input bit v, input logic [31:0] d,
                      input logic [3:0] b, input bit e);
    int          cur;
    logic [31:0] w;
    logic [1:0]  kf;
    logic [8:0]  base;
    string       t;
    chk(exp_t[k % 8], {tx_ctrl, tx_data}, exp_w[k % 8]);
    bx_sync = s; obj_valid = v; obj_data = d; bx_num = b; bx_err = e;
    cur = s ? 0 : mnext;
    if (cur == 0) begin mbcn = b; merr = e; end
    kf = 2'b00;
    if (cur == FW - 1) begin
      w = {18'd0, merr, mbcn, 9'd0};
      t = {ph, " R5 R6 R8 trailer"};
    end else begin
      w = v ? d : 32'd0;
      if (cur == 0) begin
        w[7:0] = 8'hBC; kf = 2'b01;
        t = {ph, " R4 R3 R2 first word"};
      end else t = {ph, " R3 R2 R8 payload"};
    end
    base = (cur == 0) ? 9'h1FF : mcrc;
    mcrc = ref_crc(base, w);
    if (cur == FW - 1) w[8:0] = mcrc;
    exp_w[(k + 7) % 8] = {kf, w};
    exp_t[(k + 7) % 8] = t;
    mnext = (cur == FW - 1) ? 0 : cur + 1;
    k++;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; obj_data = '0; obj_valid = 0; bx_sync = 0; bx_num = '0; bx_err = 0;
    ph = "";
    repeat (3) @(negedge clk);
    obj_data = 32'hFFFF_FFFF; obj_valid = 1; bx_sync = 1; bx_num = 4'hF; bx_err = 1;
    @(negedge clk);
    chk("R1 output during reset", {tx_ctrl, tx_data}, 34'd0);
    @(negedge clk);
    chk("R1 output during reset, inputs active", {tx_ctrl, tx_data}, 34'd0);
    bx_sync = 0; obj_valid = 0;
    // release at a falling edge; model restarts at position 0
    rst_n = 1'b1; k = 0; mnext = 0; mcrc = 9'h1FF; mbcn = '0; merr = 0;
    for (int i = 0; i < 8; i++) begin exp_w[i] = '0; exp_t[i] = "R1 after release"; end

    // R7: no sync, no objects: free-running empty frames
    ph = "R7";
    for (int i = 0; i < 50; i++)
      step(0, 0, $urandom, 4'($urandom), 1'($urandom));

    // aligned random traffic with occasional missing sync
    ph = "aligned";
    for (int i = 0; i < 2100; i++) begin
      bit s = (mnext == 0) && ($urandom_range(3) != 0);
      step(s, 1'($urandom), $urandom, 4'($urandom), ($urandom_range(7) == 0));
    end

    // R2: sync at arbitrary positions truncating frames
    ph = "R2 truncate";
    for (int i = 0; i < 700; i++)
      step(($urandom_range(4) == 0), 1'($urandom), $urandom, 4'($urandom), 1'($urandom));

    // directed: sync on consecutive clocks, then all-ones data at every slot
    ph = "R2 back-to-back sync";
    for (int i = 0; i < 4; i++) step(1, 1, 32'hFFFF_FFFF, 4'hA, 1);
    ph = "R3 R5 all ones";
    for (int i = 0; i < 14; i++) step(i == 0, 1, 32'hFFFF_FFFF, 4'hF, 1);

    ph = "flush";
    for (int i = 0; i < 10; i++) step(0, 0, 32'd0, 4'd0, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule